// File: doc/BRIEF.md
# Windowed Register File Controller

This block keeps a rotating sixteen-register view over a larger physical file of general registers and carries out the register-window operations of a processor pipeline. A window base, counted in groups of four registers, selects where the logical view sits in the physical file. A live-frame mask marks which groups belong to active call frames. On a procedure entry the block allocates a new frame and adjusts the stack register. On a windowed return it releases the frame and produces the return address.

When an entry would overwrite a live frame, or a return lands on a frame that has been spilled, the block reports a spill or fill exception of size 4, 8 or 12. It records the previous base and the faulting PC so that the handler can find the frame. It also supports explicit rotation, direct base writes, restore of the saved base, and the stack-pointer-move check. Every operation completes in one cycle. Exception and return results appear on registered, valid-qualified outputs in the cycle after the operation. Instruction decode and the spill and fill handlers sit outside the block.

Top module: `win_regfile_ctl`

## Requirements
- R1: Logical register r (0 to 15) maps to physical index (base*4 + r) modulo NAREG, and the base wraps modulo NAREG/4. Opcode 7 writes op_data to logical register op_s. Opcode 4 loads the base from op_data modulo NAREG/4. rd_data combinationally shows logical register rd_idx.
- R2: After reset the base is 0, the live-frame mask is 1 (only frame 0), the status fields and epc1 are 0, and exc_valid and ret_valid are low.
- R3: Entry (opcode 1) is illegal when op_s > 3, or unless window-overflow-enable is 1 and exception mode is 0. An illegal entry reports code 1, sets exception mode, loads epc1 with op_pc, and leaves the base unchanged.
- R4: On a legal entry with no overflow, logical register (callinc*4 + op_s[1:0]) receives logical register op_s minus op_imm*8. The base then advances by callinc, and the live bit of the new base is set.
- R5: An entry overflows when any of the callinc frames directly above the base is live. The base then advances by n, the distance to the first live frame above it. The code is 2, 3 or 4 (spill of 4, 8 or 12) when the next live frame beyond that one is 1, 2, or 3 or more frames further on. No register is written and the mask is unchanged.
- R6: On any overflow or underflow, the saved-base field takes the base from before the operation, exception mode is set, and epc1 takes op_pc.
- R7: Return (opcode 2) takes n from bits 31:30 of logical register 0. Let m be the distance (1, 2 or 3, nearest first) to the nearest live frame below the base, or 0 if there is none. The return is illegal (code 1, base unchanged) when n is 0, when m is not 0 and differs from n, or when the enable/exception-mode condition of R3 fails.
- R8: On a legal return the base moves down by n. If the new base frame is live, the old base bit is cleared, ret_valid pulses, and ret_pc is op_pc[31:30] joined with bits 29:0 of logical register 0.
- R9: If the new base frame after a legal return is not live, the block reports underflow code 5, 6 or 7 for n = 1, 2 or 3, and the mask is left unchanged.
- R10: Opcode 3 rotates the base by op_s taken as a signed 4-bit value. Opcode 5 loads the base from the saved-base field.
- R11: Opcode 6 reports code 8 (stack move fault), sets exception mode and loads epc1 when none of the three frames below the base is live. Otherwise it reports nothing.
- R12: exc_valid and ret_valid are high only in the cycle after an accepted operation that produced them. Opcode 8 writes the status: op_data[0] is enable, [1] exception mode, [3:2] callinc, [4+:log2(NAREG/4)] saved base. Opcode 9 writes the live-frame mask from op_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| op_s | input | 4 | Register operand or rotate amount |
| op_imm | input | 12 | Frame size in 8-byte units for entry |
| op_pc | input | 32 | PC of the operation |
| op_data | input | 32 | Write data for register, base, status or mask writes |
| rd_idx | input | 4 | Logical register read select |
| rd_data | output | 32 | Logical register read data |
| win_base | output | log2(NAREG/4) | Current window base |
| win_start | output | NAREG/4 | Live-frame mask |
| st_woe | output | 1 | Window-overflow enable |
| st_excm | output | 1 | Exception mode |
| st_callinc | output | 2 | Call increment |
| st_owb | output | log2(NAREG/4) | Saved old window base |
| epc1 | output | 32 | Level-1 exception PC |
| exc_valid | output | 1 | Exception report strobe |
| exc_code | output | 4 | Exception code |
| ret_valid | output | 1 | Successful return strobe |
| ret_pc | output | 32 | Return PC |

## Verification
The assertions check, on every cycle, how reports relate to the state. Each exception leaves exception mode set and epc1 holding the PC of the faulting operation. Spills and fills save the prior base. Illegal and stack-move faults leave the base alone. A return report never coincides with an exception and keeps the caller's top PC bits. Only the directed scenarios can show the specific values: the spill size chosen by the frame distances, the fill size, the stack arithmetic, the modulo mapping across the wrap, and the signed rotation.

// File: rtl/win_regfile_ctl.sv
module win_regfile_ctl #(
  parameter int NAREG = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [3:0]                   op_code,
  input  logic [3:0]                   op_s,
  input  logic [11:0]                  op_imm,
  input  logic [31:0]                  op_pc,
  input  logic [31:0]                  op_data,
  input  logic [3:0]                   rd_idx,
  output logic [31:0]                  rd_data,
  output logic [$clog2(NAREG/4)-1:0]   win_base,
  output logic [NAREG/4-1:0]           win_start,
  output logic                         st_woe,
  output logic                         st_excm,
  output logic [1:0]                   st_callinc,
  output logic [$clog2(NAREG/4)-1:0]   st_owb,
  output logic [31:0]                  epc1,
  output logic                         exc_valid,
  output logic [3:0]                   exc_code,
  output logic                         ret_valid,
  output logic [31:0]                  ret_pc
);
  localparam int NF = NAREG / 4;
  localparam int BW = $clog2(NF);
  localparam int AW = $clog2(NAREG);

  localparam logic [3:0] OP_ENTRY = 4'd1, OP_RETW = 4'd2, OP_ROTW = 4'd3,
                         OP_WBASE = 4'd4, OP_RESTORE = 4'd5, OP_MOVSP = 4'd6,
                         OP_WREG = 4'd7, OP_WSTAT = 4'd8, OP_WSTART = 4'd9;
  localparam logic [3:0] EX_ILL = 4'd1, EX_OV4 = 4'd2, EX_OV8 = 4'd3, EX_OV12 = 4'd4,
                         EX_UN4 = 4'd5, EX_UN8 = 4'd6, EX_UN12 = 4'd7, EX_ALLOCA = 4'd8;

  logic [31:0]    rf [NAREG];
  logic [BW-1:0]  base, owb;
  logic [NF-1:0]  ws;
  logic           woe, excm;
  logic [1:0]     callinc;

  function automatic logic [AW-1:0] pidx(input logic [BW-1:0] b, input logic [3:0] r);
    return {b, 2'b00} + AW'(r);
  endfunction

  function automatic logic [BW:0] ctz(input logic [NF-1:0] v);
    logic [BW:0] k;
    k = (BW+1)'(NF);
    for (int i = NF - 1; i >= 0; i--)
      if (v[i]) k = (BW+1)'(i);
    return k;
  endfunction

  assign win_base   = base;
  assign win_start  = ws;
  assign st_woe     = woe;
  assign st_excm    = excm;
  assign st_callinc = callinc;
  assign st_owb     = owb;
  assign rd_data    = rf[pidx(base, rd_idx)];

  wire en_ok = woe && !excm;

  // frames above the base, nearest first in bit 0
  logic [BW-1:0] sh;
  logic [NF-1:0] rot;
  assign sh = base + BW'(1);
  always_comb
    for (int i = 0; i < NF; i++) rot[i] = ws[sh + BW'(i)];

  wire [NF-1:0] cmask = {{(NF-3){1'b0}}, callinc == 2'd3, callinc[1], |callinc};
  wire          ovf   = |(rot & cmask);
  wire [BW:0]   n_ov  = ctz(rot) + (BW+1)'(1);
  wire [BW:0]   gap   = ctz(rot >> n_ov);
  wire [3:0]    ov_code = (gap == '0) ? EX_OV4 : (gap == (BW+1)'(1)) ? EX_OV8 : EX_OV12;

  wire          ent_ill = (op_s > 4'd3) || !en_ok;
  wire [31:0]   sp_val  = rf[pidx(base, op_s)] - {17'd0, op_imm, 3'b000};
  wire [AW-1:0] ent_dst = pidx(base, {callinc, op_s[1:0]});
  wire [BW-1:0] base_ent = base + BW'(callinc);

  wire [31:0]   r0 = rf[pidx(base, 4'd0)];
  wire [1:0]    rn = r0[31:30];
  wire [BW-1:0] bm1 = base - BW'(1), bm2 = base - BW'(2), bm3 = base - BW'(3);
  wire [1:0]    m = ws[bm1] ? 2'd1 : ws[bm2] ? 2'd2 : ws[bm3] ? 2'd3 : 2'd0;
  wire          ret_ill = (rn == 2'd0) || (m != 2'd0 && m != rn) || !en_ok;
  wire [BW-1:0] base_ret = base - BW'(rn);
  wire [3:0]    un_code = (rn == 2'd1) ? EX_UN4 : (rn == 2'd2) ? EX_UN8 : EX_UN12;
  wire          sp_fault = !(ws[bm1] || ws[bm2] || ws[bm3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NAREG; i++) rf[i] <= '0;
      base <= '0; owb <= '0; ws <= NF'(1);
      woe <= 1'b0; excm <= 1'b0; callinc <= 2'd0; epc1 <= '0;
      exc_valid <= 1'b0; exc_code <= '0; ret_valid <= 1'b0; ret_pc <= '0;
    end else begin
      exc_valid <= 1'b0;
      ret_valid <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_ENTRY:
            if (ent_ill) begin
              exc_valid <= 1'b1; exc_code <= EX_ILL; excm <= 1'b1; epc1 <= op_pc;
            end else if (ovf) begin
              base <= base + BW'(n_ov); owb <= base; excm <= 1'b1; epc1 <= op_pc;
              exc_valid <= 1'b1; exc_code <= ov_code;
            end else begin
              rf[ent_dst] <= sp_val;
              base <= base_ent;
              ws <= ws | (NF'(1) << base_ent);
            end
          OP_RETW:
            if (ret_ill) begin
              exc_valid <= 1'b1; exc_code <= EX_ILL; excm <= 1'b1; epc1 <= op_pc;
            end else begin
              base <= base_ret;
              if (ws[base_ret]) begin
                ws <= ws & ~(NF'(1) << base);
                ret_valid <= 1'b1;
                ret_pc <= {op_pc[31:30], r0[29:0]};
              end else begin
                owb <= base; excm <= 1'b1; epc1 <= op_pc;
                exc_valid <= 1'b1; exc_code <= un_code;
              end
            end
          OP_ROTW:    base <= base + BW'($signed(op_s));
          OP_WBASE:   base <= op_data[BW-1:0];
          OP_RESTORE: base <= owb;
          OP_MOVSP:
            if (sp_fault) begin
              exc_valid <= 1'b1; exc_code <= EX_ALLOCA; excm <= 1'b1; epc1 <= op_pc;
            end
          OP_WREG:    rf[pidx(base, op_s)] <= op_data;
          OP_WSTAT: begin
            woe <= op_data[0]; excm <= op_data[1];
            callinc <= op_data[3:2]; owb <= op_data[4 +: BW];
          end
          OP_WSTART:  ws <= op_data[NF-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

module win_regfile_ctl_chk #(
  parameter int NF = 16,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [31:0]   op_pc,
  input logic [BW-1:0] win_base,
  input logic [NF-1:0] win_start,
  input logic          st_excm,
  input logic [BW-1:0] st_owb,
  input logic [31:0]   epc1,
  input logic          exc_valid,
  input logic [3:0]    exc_code,
  input logic          ret_valid,
  input logic [31:0]   ret_pc
);
  AST_EXC_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid || ret_valid) |-> $past(op_valid)); // R12
  AST_EXC_SETS_EXCM: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> st_excm); // R6
  AST_EXC_EPC: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> epc1 == $past(op_pc)); // R6
  AST_SPILL_OWB: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_code >= 4'd2 && exc_code <= 4'd7) |-> st_owb == $past(win_base)); // R6
  AST_ILL_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && (exc_code == 4'd1 || exc_code == 4'd8)) |-> win_base == $past(win_base)); // R3
  AST_RET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) ret_valid |-> !exc_valid); // R8
  AST_RET_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n) ret_valid |-> ret_pc[31:30] == $past(op_pc[31:30])); // R8
  AST_ENTRY_LIVE: assert property (@(posedge clk) disable iff (!rst_n) ($past(op_valid && op_code == 4'd1) && !exc_valid) |-> win_start[win_base]); // R4
endmodule

bind win_regfile_ctl win_regfile_ctl_chk #(.NF(NF), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_pc(op_pc),
  .win_base(win_base), .win_start(win_start), .st_excm(st_excm), .st_owb(st_owb),
  .epc1(epc1), .exc_valid(exc_valid), .exc_code(exc_code),
  .ret_valid(ret_valid), .ret_pc(ret_pc)
);

// File: tb/test_win_regfile_ctl.sv
`timescale 1ns/1ps
module test_win_regfile_ctl;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [3:0] op_code = 0, op_s = 0, rd_idx = 0;
  logic [11:0] op_imm = 0;
  logic [31:0] op_pc = 0, op_data = 0;
  logic [31:0] rd_data, epc1, ret_pc;
  logic [3:0] win_base, st_owb, exc_code;
  logic [15:0] win_start;
  logic st_woe, st_excm, exc_valid, ret_valid;
  logic [1:0] st_callinc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  win_regfile_ctl #(.NAREG(64)) i_win_regfile_ctl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_s(op_s),
    .op_imm(op_imm), .op_pc(op_pc), .op_data(op_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .win_base(win_base), .win_start(win_start), .st_woe(st_woe), .st_excm(st_excm),
    .st_callinc(st_callinc), .st_owb(st_owb), .epc1(epc1), .exc_valid(exc_valid),
    .exc_code(exc_code), .ret_valid(ret_valid), .ret_pc(ret_pc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] c, input logic [3:0] s, input logic [11:0] imm,
                    input logic [31:0] pc, input logic [31:0] d);
    op_valid = 1; op_code = c; op_s = s; op_imm = imm; op_pc = pc; op_data = d;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic rd(input logic [3:0] r, output logic [31:0] v);
    rd_idx = r; #0.5; v = rd_data;
  endtask

  // enable=1, exception mode=0, given callinc
  task automatic prep(input logic [3:0] b, input logic [15:0] live, input logic [1:0] ci);
    op(4'd8, 0, 0, 0, 32'h1 | (32'(ci) << 2));
    op(4'd4, 0, 0, 0, 32'(b));
    op(4'd9, 0, 0, 0, 32'(live));
  endtask

  task automatic t_reset;
    chk("R2 base", 32'(win_base), 0);
    chk("R2 mask", 32'(win_start), 1);
    chk("R2 excm", 32'(st_excm), 0);
    chk("R2 epc1", epc1, 0);
    chk("R2 exc_valid", 32'(exc_valid), 0);
    chk("R2 ret_valid", 32'(ret_valid), 0);
  endtask

  task automatic t_mapping;
    logic [31:0] v;
    prep(0, 1, 1);
    op(4'd7, 4'd5, 0, 0, 32'hAAAA_0005);
    op(4'd3, 4'd1, 0, 0, 0);
    rd(4'd1, v); chk("R1 rotated view", v, 32'hAAAA_0005);
    op(4'd4, 0, 0, 0, 32'd15);
    op(4'd7, 4'd7, 0, 0, 32'hBBBB_0007);
    op(4'd4, 0, 0, 0, 32'd0);
    rd(4'd3, v); chk("R1 wrap modulo NAREG", v, 32'hBBBB_0007);
    op(4'd4, 0, 0, 0, 32'd17);
    chk("R1 base modulo", 32'(win_base), 1);
  endtask

  task automatic t_entry_illegal;
    prep(0, 1, 1);
    op(4'd8, 0, 0, 0, 32'h4);
    op(4'd1, 4'd1, 0, 32'h300, 0);
    chk("R3 woe clear code", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h11);
    chk("R3 epc1", epc1, 32'h300);
    chk("R3 excm", 32'(st_excm), 1);
    chk("R3 base held", 32'(win_base), 0);
    prep(0, 1, 1);
    op(4'd1, 4'd4, 0, 32'h304, 0);
    chk("R3 s>3", 32'(exc_code), 1);
    op(4'd8, 0, 0, 0, 32'h7);
    op(4'd1, 4'd1, 0, 32'h308, 0);
    chk("R3 excm set", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h11);
  endtask

  task automatic t_entry_ok;
    logic [31:0] v;
    prep(0, 1, 1);
    op(4'd7, 4'd1, 0, 0, 32'd1000);
    op(4'd1, 4'd1, 12'd4, 32'h400, 0);
    chk("R4 no exception", 32'(exc_valid), 0);
    chk("R4 base", 32'(win_base), 1);
    chk("R4 mask", 32'(win_start), 32'h3);
    rd(4'd1, v); chk("R4 new sp", v, 32'd968);
  endtask

  task automatic t_overflow;
    prep(0, 16'h7, 1);
    op(4'd1, 4'd1, 0, 32'h200, 0);
    chk("R5 spill4 code", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h12);
    chk("R5 base", 32'(win_base), 1);
    chk("R5 mask held", 32'(win_start), 32'h7);
    chk("R6 owb", 32'(st_owb), 0);
    chk("R6 epc1", epc1, 32'h200);
    prep(0, 16'hB, 1);
    op(4'd1, 4'd1, 0, 32'h204, 0);
    chk("R5 spill8 code", 32'(exc_code), 3);
    prep(0, 16'h3, 1);
    op(4'd1, 4'd1, 0, 32'h208, 0);
    chk("R5 spill12 code", 32'(exc_code), 4);
  endtask

  task automatic t_return;
    prep(1, 16'h3, 1);
    op(4'd7, 4'd0, 0, 0, 32'h4000_1234);
    op(4'd2, 0, 0, 32'hC000_0000, 0);
    chk("R8 ret_valid", {31'd0, ret_valid} << 4 | 32'(exc_valid), 32'h10);
    chk("R8 ret_pc", ret_pc, 32'hC000_1234);
    chk("R8 base", 32'(win_base), 0);
    chk("R8 mask", 32'(win_start), 32'h1);
    op(4'd0, 0, 0, 0, 0);
    chk("R12 pulse ends", 32'(ret_valid) | 32'(exc_valid), 0);
  endtask

  task automatic t_underflow;
    prep(2, 16'h4, 1);
    op(4'd7, 4'd0, 0, 0, 32'h8000_0000);
    op(4'd2, 0, 0, 32'h100, 0);
    chk("R9 fill8 code", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h16);
    chk("R9 base", 32'(win_base), 0);
    chk("R9 mask held", 32'(win_start), 32'h4);
    chk("R6 owb", 32'(st_owb), 2);
    chk("R6 epc1", epc1, 32'h100);
    prep(3, 16'h8, 1);
    op(4'd7, 4'd0, 0, 0, 32'hC000_0000);
    op(4'd2, 0, 0, 32'h104, 0);
    chk("R9 fill12 code", 32'(exc_code), 7);
    prep(1, 16'h2, 1);
    op(4'd7, 4'd0, 0, 0, 32'h4000_0000);
    op(4'd2, 0, 0, 32'h108, 0);
    chk("R9 fill4 code", 32'(exc_code), 5);
  endtask

  task automatic t_return_illegal;
    prep(1, 16'h3, 1);
    op(4'd7, 4'd0, 0, 0, 32'h0000_0010);
    op(4'd2, 0, 0, 32'h500, 0);
    chk("R7 n zero", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h11);
    chk("R7 base held", 32'(win_base), 1);
    prep(2, 16'h5, 1);
    op(4'd7, 4'd0, 0, 0, 32'h4000_0000);
    op(4'd2, 0, 0, 32'h504, 0);
    chk("R7 m differs", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h11);
    chk("R7 base held m", 32'(win_base), 2);
  endtask

  task automatic t_rotate;
    prep(0, 1, 1);
    op(4'd3, 4'hF, 0, 0, 0);
    chk("R10 rotate -1", 32'(win_base), 15);
    op(4'd3, 4'd3, 0, 0, 0);
    chk("R10 rotate +3 wrap", 32'(win_base), 2);
    op(4'd8, 0, 0, 0, 32'h51);
    op(4'd5, 0, 0, 0, 0);
    chk("R10 restore owb", 32'(win_base), 5);
  endtask

  task automatic t_movsp;
    prep(4, 16'h10, 1);
    op(4'd6, 0, 0, 32'h600, 0);
    chk("R11 fault", {31'd0, exc_valid} << 4 | 32'(exc_code), 32'h18);
    chk("R11 base held", 32'(win_base), 4);
    chk("R11 epc1", epc1, 32'h600);
    prep(4, 16'h14, 1);
    op(4'd6, 0, 0, 32'h604, 0);
    chk("R11 live below", 32'(exc_valid), 0);
    prep(1, 16'h8000, 1);
    op(4'd6, 0, 0, 32'h608, 0);
    chk("R11 wrap live", 32'(exc_valid), 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_entry_illegal();
    t_entry_ok();
    t_overflow();
    t_return();
    t_underflow();
    t_return_illegal();
    t_rotate();
    t_movsp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule